// File: doc/BRIEF.md
# Eight-bit ALU with packed-decimal arithmetic

This block is the arithmetic and flag logic of a small 8-bit processor. One operation code selects among add, subtract, the three bitwise logic functions, compare, bit test, test-and-set and test-and-clear of bits, the four shift and rotate forms, and increment or decrement. The block is purely combinational. It takes a register operand, a memory operand and the current sign, overflow, zero, carry and decimal flags. It returns the 8-bit result, four updated flags and a mask that tells the surrounding sequencer which flags the operation owns.

Add and subtract honour the decimal flag. When it is set, both operands are treated as packed BCD and the result is adjusted digit by digit. Shift, rotate, increment and decrement act on the memory operand, so the sequencer routes the accumulator onto that input when the target is a register. A flag whose mask bit is clear leaves the block equal to its input, so the sequencer may either latch all four flags or latch only the masked ones.

Top module: `bcd_alu`

## Requirements
- R1: Code 0 (add) returns regVal + memVal + cIn modulo 256, with C the carry out of bit 7, V set on signed overflow, N equal to result bit 7 and Z set for a zero result; flagMask, ordered N,V,Z,C from bit 3 down to bit 0, is 4'b1111.
- R2: Code 1 (subtract) returns regVal - memVal - (1 - cIn) modulo 256, with C = 1 meaning no borrow and V set on signed overflow; N and Z follow the result and flagMask is 4'b1111.
- R3: With dIn = 1, code 0 treats both operands as two packed BCD digits and returns their decimal sum, with C the decimal carry, N and Z taken from the adjusted result, and V taken from the plain binary sum.
- R4: With dIn = 1, code 1 returns the decimal difference of two packed BCD operands, with C = 1 meaning no decimal borrow, N and Z from the adjusted result, and V from the plain binary difference.
- R5: Codes 2, 3 and 4 return regVal AND, OR and XOR memVal; only N and Z are updated (flagMask 4'b1010).
- R6: Code 5 (compare) sets C when regVal >= memVal unsigned and sets N and Z from regVal - memVal. The result output equals regVal, V is untouched (flagMask 4'b1011), and dIn has no effect.
- R7: Code 6 (bit test) sets Z when (regVal AND memVal) is zero and copies memVal bit 7 to N and bit 6 to V. The result output equals regVal and C is untouched (flagMask 4'b1110).
- R8: Code 7 returns memVal OR regVal and code 8 returns memVal AND NOT regVal; both set Z when (regVal AND memVal) is zero and touch no other flag (flagMask 4'b0010).
- R9: Code 9 shifts memVal left with bit 7 going to C and a zero entering bit 0. Code 10 shifts it right with bit 0 going to C and a zero entering bit 7. Both update N, Z and C (flagMask 4'b1011).
- R10: Code 11 rotates memVal left with cIn entering bit 0 and bit 7 going to C. Code 12 rotates it right with cIn entering bit 7 and bit 0 going to C (flagMask 4'b1011).
- R11: Codes 13 and 14 return memVal + 1 and memVal - 1, wrapping modulo 256, and update only N and Z (flagMask 4'b1010); C passes through unchanged.
- R12: Every flag whose flagMask bit is 0 leaves equal to its input. Code 15 is reserved: it returns regVal with flagMask 4'b0000.
- R13: dIn affects only codes 0 and 1; for example, increment of 8'h09 with dIn = 1 returns 8'h0A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opCode | input | 4 | Operation select, codes 0 to 15 as listed in the requirements |
| regVal | input | 8 | Register operand |
| memVal | input | 8 | Memory operand; target of shift, rotate, increment and decrement |
| nIn | input | 1 | Current sign flag |
| vIn | input | 1 | Current overflow flag |
| zIn | input | 1 | Current zero flag |
| cIn | input | 1 | Current carry flag |
| dIn | input | 1 | Decimal mode flag |
| result | output | 8 | Operation result |
| nOut | output | 1 | Updated sign flag |
| vOut | output | 1 | Updated overflow flag |
| zOut | output | 1 | Updated zero flag |
| cOut | output | 1 | Updated carry flag |
| flagMask | output | 4 | Flags owned by the operation: bit 3 N, bit 2 V, bit 1 Z, bit 0 C |

## Verification
The block holds no state, so any fault in decode or in the digit chain shows at the ports in the same evaluation as the bad input: a wrong result byte, a flag that should have passed through but changed, or a mask bit that disagrees with the operation. The hardest errors to see are in decimal mode, where a wrong digit adjust or a V taken from the adjusted rather than the binary sum only shows on operand pairs that carry across a digit or change sign in binary. The directed cases are chosen to reach those pairs, together with the wrap points of 8'h00 and 8'hFF.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_CMP  = 4'd5,
    OP_BIT  = 4'd6,
    OP_TSET = 4'd7,
    OP_TCLR = 4'd8,
    OP_SHL  = 4'd9,
    OP_SHR  = 4'd10,
    OP_ROTL = 4'd11,
    OP_ROTR = 4'd12,
    OP_INC  = 4'd13,
    OP_DEC  = 4'd14,
    OP_NONE = 4'd15
  } aluOp_e;

  typedef enum logic [2:0] {
    U_ARITH, U_LOGIC, U_SHIFT, U_STEP, U_REG
  } unit_e;

  typedef enum logic [2:0] {
    L_AND, L_OR, L_XOR, L_SET, L_CLR
  } logicSel_e;

  // flag positions inside the 4-bit flag vectors and the mask
  localparam int F_N = 3;
  localparam int F_V = 2;
  localparam int F_Z = 1;
  localparam int F_C = 0;

  typedef struct packed {
    unit_e     unit;
    logic      subtract;
    logic      decimalOk;
    logic      forceCarry;
    logicSel_e logicSel;
    logic      shiftLeft;
    logic      rotate;
    logic      stepDown;
    logic      keepReg;
    logic      zFromAnd;
    logic      nvFromMem;
    logic [3:0] mask;
  } aluCtrl_t;

endpackage

// File: rtl/bcd_alu_ctrl.sv
module bcd_alu_ctrl
  import bcd_alu_pkg::*;
(
  input  logic [3:0] opCode,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl          = '0;
    ctrl.unit     = U_REG;
    ctrl.logicSel = L_AND;
    unique case (aluOp_e'(opCode))
      OP_ADD: begin
        ctrl.unit = U_ARITH; ctrl.decimalOk = 1'b1; ctrl.mask = 4'b1111;
      end
      OP_SUB: begin
        ctrl.unit = U_ARITH; ctrl.subtract = 1'b1; ctrl.decimalOk = 1'b1;
        ctrl.mask = 4'b1111;
      end
      OP_AND: begin ctrl.unit = U_LOGIC; ctrl.logicSel = L_AND; ctrl.mask = 4'b1010; end
      OP_OR:  begin ctrl.unit = U_LOGIC; ctrl.logicSel = L_OR;  ctrl.mask = 4'b1010; end
      OP_XOR: begin ctrl.unit = U_LOGIC; ctrl.logicSel = L_XOR; ctrl.mask = 4'b1010; end
      OP_CMP: begin
        ctrl.unit = U_ARITH; ctrl.subtract = 1'b1; ctrl.forceCarry = 1'b1;
        ctrl.keepReg = 1'b1; ctrl.mask = 4'b1011;
      end
      OP_BIT: begin
        ctrl.unit = U_LOGIC; ctrl.logicSel = L_AND; ctrl.keepReg = 1'b1;
        ctrl.zFromAnd = 1'b1; ctrl.nvFromMem = 1'b1; ctrl.mask = 4'b1110;
      end
      OP_TSET: begin
        ctrl.unit = U_LOGIC; ctrl.logicSel = L_SET; ctrl.zFromAnd = 1'b1;
        ctrl.mask = 4'b0010;
      end
      OP_TCLR: begin
        ctrl.unit = U_LOGIC; ctrl.logicSel = L_CLR; ctrl.zFromAnd = 1'b1;
        ctrl.mask = 4'b0010;
      end
      OP_SHL:  begin ctrl.unit = U_SHIFT; ctrl.shiftLeft = 1'b1; ctrl.mask = 4'b1011; end
      OP_SHR:  begin ctrl.unit = U_SHIFT; ctrl.mask = 4'b1011; end
      OP_ROTL: begin
        ctrl.unit = U_SHIFT; ctrl.shiftLeft = 1'b1; ctrl.rotate = 1'b1; ctrl.mask = 4'b1011;
      end
      OP_ROTR: begin ctrl.unit = U_SHIFT; ctrl.rotate = 1'b1; ctrl.mask = 4'b1011; end
      OP_INC:  begin ctrl.unit = U_STEP; ctrl.mask = 4'b1010; end
      OP_DEC:  begin ctrl.unit = U_STEP; ctrl.stepDown = 1'b1; ctrl.mask = 4'b1010; end
      default: begin ctrl.unit = U_REG; ctrl.mask = 4'b0000; end
    endcase
  end

  // reserved code owns no flag
  always_comb begin
    if (opCode == 4'd15)
      assert_reserved_no_flags_R12: assert (ctrl.mask == 4'b0000)
        else $error("reserved code claims flags");
  end

endmodule

// File: rtl/bcd_alu_datapath.sv
module bcd_alu_datapath
  import bcd_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] regVal,
  input  logic [DATA_W-1:0] memVal,
  input  logic [3:0]        flagsIn,
  input  logic              dIn,
  output logic [DATA_W-1:0] resVal,
  output logic [3:0]        flagsOut
);

  localparam int MSB    = DATA_W - 1;
  localparam int DIGITS = DATA_W / 4;

  logic cIn;
  assign cIn = flagsIn[F_C];

  // binary adder shared by add, subtract and compare
  logic              carryIn;
  logic [MSB:0]      addend;
  logic [DATA_W:0]   binSum;
  logic              binOvf;
  assign carryIn = ctrl.forceCarry ? 1'b1 : cIn;
  assign addend  = ctrl.subtract ? ~memVal : memVal;
  assign binSum  = {1'b0, regVal} + {1'b0, addend} + {{DATA_W{1'b0}}, carryIn};
  assign binOvf  = (regVal[MSB] == addend[MSB]) && (binSum[MSB] != regVal[MSB]);

  // decimal digit chain: carry for add, borrow for subtract
  logic [DIGITS:0] decChain;
  logic [MSB:0]    decVal;
  assign decChain[0] = ctrl.subtract ? ~cIn : cIn;

  for (genvar g = 0; g < DIGITS; g++) begin : gDigit
    logic [4:0] rawDigit;
    logic [4:0] adjDigit;
    logic       overRange;
    always_comb begin
      if (ctrl.subtract) begin
        rawDigit  = {1'b0, regVal[4*g +: 4]} - {1'b0, memVal[4*g +: 4]}
                    - {4'd0, decChain[g]};
        overRange = rawDigit[4];
        adjDigit  = overRange ? rawDigit - 5'd6 : rawDigit;
      end else begin
        rawDigit  = {1'b0, regVal[4*g +: 4]} + {1'b0, memVal[4*g +: 4]}
                    + {4'd0, decChain[g]};
        overRange = rawDigit > 5'd9;
        adjDigit  = overRange ? rawDigit + 5'd6 : rawDigit;
      end
    end
    assign decVal[4*g +: 4] = adjDigit[3:0];
    assign decChain[g+1]    = overRange;
  end

  logic         useDec;
  logic [MSB:0] arithRes;
  logic         arithC;
  assign useDec   = dIn & ctrl.decimalOk;
  assign arithRes = useDec ? decVal : binSum[MSB:0];
  assign arithC   = useDec ? (ctrl.subtract ? ~decChain[DIGITS] : decChain[DIGITS])
                           : binSum[DATA_W];

  // bitwise unit
  logic [MSB:0] andVal;
  logic [MSB:0] logicRes;
  assign andVal = regVal & memVal;
  always_comb begin
    unique case (ctrl.logicSel)
      L_OR:    logicRes = regVal | memVal;
      L_XOR:   logicRes = regVal ^ memVal;
      L_SET:   logicRes = memVal | regVal;
      L_CLR:   logicRes = memVal & ~regVal;
      default: logicRes = andVal;
    endcase
  end

  // shift and rotate unit
  logic         fillBit;
  logic [MSB:0] shiftRes;
  logic         shiftC;
  assign fillBit  = ctrl.rotate ? cIn : 1'b0;
  assign shiftRes = ctrl.shiftLeft ? {memVal[MSB-1:0], fillBit} : {fillBit, memVal[MSB:1]};
  assign shiftC   = ctrl.shiftLeft ? memVal[MSB] : memVal[0];

  // increment / decrement unit
  logic [MSB:0] stepRes;
  assign stepRes = ctrl.stepDown ? memVal - 1'b1 : memVal + 1'b1;

  // unit select and flag derivation
  logic [MSB:0] unitRes;
  logic [3:0]   flagsNew;
  always_comb begin
    unique case (ctrl.unit)
      U_ARITH: unitRes = arithRes;
      U_LOGIC: unitRes = logicRes;
      U_SHIFT: unitRes = shiftRes;
      U_STEP:  unitRes = stepRes;
      default: unitRes = regVal;
    endcase
    resVal = ctrl.keepReg ? regVal : unitRes;

    flagsNew[F_N] = ctrl.nvFromMem ? memVal[MSB]   : unitRes[MSB];
    flagsNew[F_V] = ctrl.nvFromMem ? memVal[MSB-1] : binOvf;
    flagsNew[F_Z] = ctrl.zFromAnd  ? (andVal == '0) : (unitRes == '0);
    flagsNew[F_C] = (ctrl.unit == U_ARITH) ? arithC : shiftC;
    for (int i = 0; i < 4; i++)
      flagsOut[i] = ctrl.mask[i] ? flagsNew[i] : flagsIn[i];
  end

  function automatic logic isBcd(input logic [MSB:0] v);
    logic ok;
    ok = 1'b1;
    for (int d = 0; d < DIGITS; d++)
      if (v[4*d +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  always_comb begin
    if (ctrl.unit == U_ARITH && ctrl.forceCarry)
      assert_cmp_carry_R6: assert (flagsOut[F_C] == (regVal >= memVal))
        else $error("compare carry disagrees with magnitude");
    if (ctrl.unit == U_LOGIC && ctrl.logicSel == L_SET)
      assert_tset_covers_R8: assert ((resVal & regVal) == regVal)
        else $error("test-and-set lost a bit");
    if (ctrl.unit == U_LOGIC && ctrl.logicSel == L_CLR)
      assert_tclr_clears_R8: assert ((resVal & regVal) == '0)
        else $error("test-and-clear left a bit");
    if (ctrl.unit == U_STEP)
      assert_step_keeps_carry_R11: assert (flagsOut[F_C] == cIn)
        else $error("step changed carry");
    if (useDec && isBcd(regVal) && isBcd(memVal))
      assert_dec_digits_R3: assert (isBcd(resVal))
        else $error("decimal result has a non-decimal digit");
  end

endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
  import bcd_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] regVal,
  input  logic [DATA_W-1:0] memVal,
  input  logic              nIn,
  input  logic              vIn,
  input  logic              zIn,
  input  logic              cIn,
  input  logic              dIn,
  output logic [DATA_W-1:0] result,
  output logic              nOut,
  output logic              vOut,
  output logic              zOut,
  output logic              cOut,
  output logic [3:0]        flagMask
);

  aluCtrl_t   ctrl;
  logic [3:0] flagsIn;
  logic [3:0] flagsOut;

  assign flagsIn = {nIn, vIn, zIn, cIn};

  bcd_alu_ctrl uCtrl (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  bcd_alu_datapath #(.DATA_W(DATA_W)) uPath (
    .ctrl     (ctrl),
    .regVal   (regVal),
    .memVal   (memVal),
    .flagsIn  (flagsIn),
    .dIn      (dIn),
    .resVal   (result),
    .flagsOut (flagsOut)
  );

  assign {nOut, vOut, zOut, cOut} = flagsOut;
  assign flagMask = ctrl.mask;

  always_comb begin
    for (int i = 0; i < 4; i++)
      if (!flagMask[i])
        assert_masked_flag_held_R12: assert (flagsOut[i] == flagsIn[i])
          else $error("unowned flag changed");
  end

endmodule

// File: tb/tb_bcd_alu.sv
module tb_bcd_alu;

  logic       clk = 1'b0;
  logic [3:0] opCode = '0;
  logic [7:0] regVal = '0;
  logic [7:0] memVal = '0;
  logic       nIn = 1'b0, vIn = 1'b0, zIn = 1'b0, cIn = 1'b0, dIn = 1'b0;
  logic [7:0] result;
  logic       nOut, vOut, zOut, cOut;
  logic [3:0] flagMask;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  bcd_alu dut (
    .opCode(opCode), .regVal(regVal), .memVal(memVal),
    .nIn(nIn), .vIn(vIn), .zIn(zIn), .cIn(cIn), .dIn(dIn),
    .result(result), .nOut(nOut), .vOut(vOut), .zOut(zOut), .cOut(cOut),
    .flagMask(flagMask)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive on the falling edge, sample a quarter period later
  task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] m,
                       input logic [3:0] nvzc, input logic d);
    @(negedge clk);
    opCode = op; regVal = a; memVal = m;
    {nIn, vIn, zIn, cIn} = nvzc; dIn = d;
    #5;
  endtask

  task automatic expect_out(input string req, input logic [7:0] res,
                            input logic [3:0] nvzc, input logic [3:0] mask);
    chk(req, "result", int'(result), int'(res));
    chk(req, "flags NVZC", int'({nOut, vOut, zOut, cOut}), int'(nvzc));
    chk(req, "mask", int'(flagMask), int'(mask));
  endtask

  task automatic test_idle();
    #5;
    expect_out("R1", 8'h00, 4'b0010, 4'b1111);
  endtask

  task automatic test_add_bin();
    apply(4'd0, 8'h50, 8'h50, 4'b0000, 1'b0); expect_out("R1", 8'hA0, 4'b1100, 4'b1111);
    apply(4'd0, 8'hFF, 8'h01, 4'b0000, 1'b0); expect_out("R1", 8'h00, 4'b0011, 4'b1111);
    apply(4'd0, 8'h01, 8'h01, 4'b0001, 1'b0); expect_out("R1", 8'h03, 4'b0000, 4'b1111);
  endtask

  task automatic test_sub_bin();
    apply(4'd1, 8'h50, 8'hB0, 4'b0001, 1'b0); expect_out("R2", 8'hA0, 4'b1100, 4'b1111);
    apply(4'd1, 8'h05, 8'h03, 4'b0000, 1'b0); expect_out("R2", 8'h01, 4'b0001, 4'b1111);
    apply(4'd1, 8'h00, 8'h01, 4'b0001, 1'b0); expect_out("R2", 8'hFF, 4'b1000, 4'b1111);
  endtask

  task automatic test_add_dec();
    apply(4'd0, 8'h58, 8'h46, 4'b0001, 1'b1); expect_out("R3", 8'h05, 4'b0101, 4'b1111);
    apply(4'd0, 8'h99, 8'h01, 4'b0000, 1'b1); expect_out("R3", 8'h00, 4'b0011, 4'b1111);
  endtask

  task automatic test_sub_dec();
    apply(4'd1, 8'h46, 8'h12, 4'b0001, 1'b1); expect_out("R4", 8'h34, 4'b0001, 4'b1111);
    apply(4'd1, 8'h12, 8'h21, 4'b0001, 1'b1); expect_out("R4", 8'h91, 4'b1000, 4'b1111);
    apply(4'd1, 8'h00, 8'h00, 4'b0000, 1'b1); expect_out("R4", 8'h99, 4'b1000, 4'b1111);
  endtask

  task automatic test_logic();
    apply(4'd2, 8'hF0, 8'h0F, 4'b0101, 1'b0); expect_out("R5", 8'h00, 4'b0111, 4'b1010);
    apply(4'd3, 8'h80, 8'h01, 4'b0010, 1'b0); expect_out("R5", 8'h81, 4'b1000, 4'b1010);
    apply(4'd4, 8'hFF, 8'hFF, 4'b0000, 1'b0); expect_out("R5", 8'h00, 4'b0010, 4'b1010);
  endtask

  task automatic test_compare();
    apply(4'd5, 8'h40, 8'h40, 4'b0100, 1'b0); expect_out("R6", 8'h40, 4'b0111, 4'b1011);
    apply(4'd5, 8'h10, 8'h20, 4'b0000, 1'b0); expect_out("R6", 8'h10, 4'b1000, 4'b1011);
    apply(4'd5, 8'h20, 8'h10, 4'b0000, 1'b1); expect_out("R6", 8'h20, 4'b0001, 4'b1011);
  endtask

  task automatic test_bit();
    apply(4'd6, 8'h0F, 8'hC0, 4'b0001, 1'b0); expect_out("R7", 8'h0F, 4'b1111, 4'b1110);
    apply(4'd6, 8'h01, 8'h3F, 4'b1100, 1'b0); expect_out("R7", 8'h01, 4'b0000, 4'b1110);
  endtask

  task automatic test_tset_tclr();
    apply(4'd7, 8'h0F, 8'hF0, 4'b1000, 1'b0); expect_out("R8", 8'hFF, 4'b1010, 4'b0010);
    apply(4'd8, 8'h0F, 8'hFF, 4'b0010, 1'b0); expect_out("R8", 8'hF0, 4'b0000, 4'b0010);
  endtask

  task automatic test_shift();
    apply(4'd9,  8'h77, 8'h81, 4'b0000, 1'b0); expect_out("R9", 8'h02, 4'b0001, 4'b1011);
    apply(4'd10, 8'h77, 8'h01, 4'b1000, 1'b0); expect_out("R9", 8'h00, 4'b0011, 4'b1011);
  endtask

  task automatic test_rotate();
    apply(4'd11, 8'h00, 8'h80, 4'b0001, 1'b0); expect_out("R10", 8'h01, 4'b0001, 4'b1011);
    apply(4'd12, 8'h00, 8'h01, 4'b0001, 1'b0); expect_out("R10", 8'h80, 4'b1001, 4'b1011);
    apply(4'd12, 8'h00, 8'h02, 4'b0000, 1'b0); expect_out("R10", 8'h01, 4'b0000, 4'b1011);
  endtask

  task automatic test_step();
    apply(4'd13, 8'h00, 8'hFF, 4'b0001, 1'b0); expect_out("R11", 8'h00, 4'b0011, 4'b1010);
    apply(4'd14, 8'h00, 8'h00, 4'b0100, 1'b0); expect_out("R11", 8'hFF, 4'b1100, 4'b1010);
  endtask

  task automatic test_reserved();
    apply(4'd15, 8'h5A, 8'h33, 4'b1010, 1'b0); expect_out("R12", 8'h5A, 4'b1010, 4'b0000);
    apply(4'd15, 8'h5A, 8'h33, 4'b0101, 1'b1); expect_out("R12", 8'h5A, 4'b0101, 4'b0000);
  endtask

  task automatic test_decimal_scope();
    apply(4'd13, 8'h00, 8'h09, 4'b0000, 1'b1); expect_out("R13", 8'h0A, 4'b0000, 4'b1010);
    apply(4'd4,  8'h09, 8'h01, 4'b0000, 1'b1); expect_out("R13", 8'h08, 4'b0000, 4'b1010);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    test_idle();
    test_add_bin();
    test_sub_bin();
    test_add_dec();
    test_sub_dec();
    test_logic();
    test_compare();
    test_bit();
    test_tset_tclr();
    test_shift();
    test_rotate();
    test_step();
    test_reserved();
    test_decimal_scope();
    finish_run();
  end

endmodule